// File: doc/BRIEF.md
# Multichannel Serial Audio Transmitter

This block turns 32-bit parallel audio samples into a three-wire serial audio stream: a bit clock, a word-select line and a data line. The block is the bus master and generates both clocks from the system clock. Samples arrive through a valid/ready write port. A one-entry holding register sits behind that port, so the source can write the next sample while the current one is shifting out.

Each word-select phase is one system word. A system word packs one to four data words back to back. Each data word is DATA_W bits long. The bit times left over in the system word form one padding block, which sits either before or after the packed data. Parameters choose:
- the packing count;
- the padding place and padding level;
- which end of the 32-bit sample holds the data;
- mute;
- the bit-clock and word-select polarities;
- whether the first data bit lags the word-select edge by one bit time.

A parameter set whose packed data does not fit in the system word is refused. The block raises an error output and never starts.

Top module: `mc_audio_tx`

## Requirements
- R1: The two-bit CHAN_SEL parameter sets the number of data words per system word. The encoding is 0 for one word, 1 for two, 2 for three and 3 for four. These words are sent contiguously, in the order the samples were accepted. Each word goes out most significant bit first.
- R2: The raw word-select level is 0 for the first SYS_W bit times of each frame (first channel phase) and 1 for the next SYS_W bit times. The `wsel` output is this raw level XOR WS_INV.
- R3: The raw bit clock has a period of 2*HALF system clocks: low for HALF clocks, then high for HALF clocks. The `bclk` output is the raw clock XOR SCK_INV. `wsel` and `sdata` change only on the clock edge that drives the raw bit clock low.
- R4: With PAD_FIRST=0, the system word carries its data bits first and its SYS_W - words*DATA_W padding bits last. With PAD_FIRST=1, the padding bits come first.
- R5: Padding bits are driven at the level of PAD_HIGH.
- R6: With ALIGN_LSB=0, a data word is taken from sample bits 31 down to 32-DATA_W. With ALIGN_LSB=1, it is taken from bits DATA_W-1 down to 0.
- R7: With MUTE=1, every data bit time drives 0 and padding still follows PAD_HIGH. Samples are still consumed at the normal rate.
- R8: With NO_DELAY=0, bit position p of a system word is driven one bit time after the word-select position p. The very first bit after start carries the padding level. With NO_DELAY=1, data and word select are aligned.
- R9: `smp_ready` is high exactly when the holding register is empty. A sample is accepted when `smp_valid` and `smp_ready` are both high on a clock edge. A continuous supply of samples is sent with no gaps.
- R10: If a data word starts while the holding register is empty, that word is sent as zeros and no sample is consumed. `underflow` is then set and stays set until reset.
- R11: If words*DATA_W exceeds SYS_W, `cfg_err` is 1 and `smp_ready` stays 0. The bus stays idle: raw clock low, raw word select low, data low. Otherwise `cfg_err` is 0.
- R12: After reset, `smp_ready` is 1 and `underflow` is 0. The bus stays idle (raw clock low, raw word select low, data 0) until the first sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_data | input | 32 | Sample word to send |
| smp_valid | input | 1 | Sample word is offered |
| smp_ready | output | 1 | Holding register is empty |
| bclk | output | 1 | Serial bit clock |
| wsel | output | 1 | Word select (channel phase) |
| sdata | output | 1 | Serial data |
| underflow | output | 1 | Sticky: a data word found no sample |
| cfg_err | output | 1 | Parameter set does not fit |

## Verification
The bench builds four instances of the block with different parameters:
- Six-bit words, four per 32-bit system word, padding first and high, MSB alignment, delayed data, half period 2. This instance covers four-word packing and the first-bit delay.
- Ten-bit words, two per 24-bit system word, padding last and low, LSB alignment, no delay, both polarities inverted, half period 3. This instance covers the other setting of every alignment and polarity control.
- Four-bit words, three per 16-bit system word, muted, padding high, half period 1. This instance shows that mute zeroes only the data bit times, and it runs at the fastest bit clock.
- Twelve-bit words, three per 32-bit system word. This set does not fit and must stay idle.

For each working instance, the feed is stopped partway through. The stream then moves from real samples to zero words, and the bench checks that the underflow flag rises and stays set.

// File: rtl/mctx_pkg.sv
package mctx_pkg;

    localparam int SAMPLE_W = 32;

    // number of data words packed in one system word for a channel-field code
    function automatic int words_per_sys(input logic [1:0] sel);
        return int'(sel) + 1;
    endfunction

    function automatic bit cfg_fits(input int dw, input int sw, input int nw);
        return (dw >= 1) && (dw <= SAMPLE_W) && (nw * dw <= sw);
    endfunction

endpackage

// File: rtl/mctx_bitclk.sv
module mctx_bitclk #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic launch,
    output logic sck_raw
);
    localparam int PERIOD = 2 * HALF;
    localparam int DIVW   = $clog2(PERIOD);

    typedef struct packed {
        logic [DIVW-1:0] div;
        logic            sck;
    } clk_st_t;

    clk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.div = '0;
            st_d.sck = 1'b0;
        end else begin
            st_d.div = (st_q.div == DIVW'(PERIOD - 1)) ? '0 : st_q.div + 1'b1;
            if (st_q.div == '0)
                st_d.sck = 1'b0;
            else if (st_q.div == DIVW'(HALF))
                st_d.sck = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign launch  = run && (st_q.div == '0);
    assign sck_raw = st_q.sck;

endmodule

// File: rtl/mctx_framer.sv
module mctx_framer #(
    parameter int SYS_W     = 32,
    parameter int DATA_W    = 16,
    parameter int NWORDS    = 2,
    parameter bit PAD_FIRST = 1'b0,
    parameter bit NO_DELAY  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic ws_now,
    output logic in_data,
    output logic word_start
);
    localparam int FRAME     = 2 * SYS_W;
    localparam int FW        = $clog2(FRAME);
    localparam int DATA_BITS = NWORDS * DATA_W;
    localparam int PADW      = (DATA_BITS > SYS_W) ? 0 : SYS_W - DATA_BITS;
    localparam int JW        = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [FW-1:0] fcnt;
        logic [JW-1:0] jcnt;
        logic          first;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic [FW-1:0] dpos, dbit;
    logic region;

    always_comb begin
        st_d = st_q;
        if (NO_DELAY)
            dpos = st_q.fcnt;
        else
            dpos = (st_q.fcnt == '0) ? FW'(FRAME - 1) : st_q.fcnt - 1'b1;
        dbit = (dpos >= FW'(SYS_W)) ? dpos - FW'(SYS_W) : dpos;
        if (PAD_FIRST)
            region = (int'(dbit) >= PADW);
        else
            region = (int'(dbit) < DATA_BITS);
        in_data    = region && !(st_q.first && !NO_DELAY);
        ws_now     = (st_q.fcnt >= FW'(SYS_W));
        word_start = in_data && (st_q.jcnt == '0);
        if (launch) begin
            st_d.fcnt  = (st_q.fcnt == FW'(FRAME - 1)) ? '0 : st_q.fcnt + 1'b1;
            st_d.first = 1'b0;
            if (in_data)
                st_d.jcnt = (st_q.jcnt == JW'(DATA_W - 1)) ? '0 : st_q.jcnt + 1'b1;
            else
                st_d.jcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mc_audio_tx.sv
module mc_audio_tx #(
    parameter int         DATA_W    = 16,
    parameter int         SYS_W     = 32,
    parameter logic [1:0] CHAN_SEL  = 2'b01,
    parameter bit         PAD_FIRST = 1'b0,
    parameter bit         PAD_HIGH  = 1'b0,
    parameter bit         ALIGN_LSB = 1'b0,
    parameter bit         MUTE      = 1'b0,
    parameter bit         SCK_INV   = 1'b0,
    parameter bit         WS_INV    = 1'b0,
    parameter bit         NO_DELAY  = 1'b0,
    parameter int         HALF      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] smp_data,
    input  logic        smp_valid,
    output logic        smp_ready,
    output logic        bclk,
    output logic        wsel,
    output logic        sdata,
    output logic        underflow,
    output logic        cfg_err
);
    import mctx_pkg::*;

    localparam int NWORDS  = words_per_sys(CHAN_SEL);
    localparam bit CFG_BAD = !cfg_fits(DATA_W, SYS_W, NWORDS);

    typedef struct packed {
        logic [SAMPLE_W-1:0] hold;
        logic                hv;
        logic [DATA_W-1:0]   sh;
        logic                sd;
        logic                ws;
        logic                run;
        logic                udf;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic launch, sck_raw, ws_now, in_data, word_start, accept;
    logic [DATA_W-1:0] picked, src;

    mctx_bitclk #(.HALF(HALF)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.run),
        .launch  (launch),
        .sck_raw (sck_raw)
    );

    mctx_framer #(
        .SYS_W     (SYS_W),
        .DATA_W    (DATA_W),
        .NWORDS    (NWORDS),
        .PAD_FIRST (PAD_FIRST),
        .NO_DELAY  (NO_DELAY)
    ) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .ws_now     (ws_now),
        .in_data    (in_data),
        .word_start (word_start)
    );

    assign smp_ready = !st_q.hv && !CFG_BAD;
    assign accept    = smp_valid && smp_ready;

    always_comb begin
        st_d   = st_q;
        picked = ALIGN_LSB ? st_q.hold[DATA_W-1:0] : st_q.hold[SAMPLE_W-1 -: DATA_W];
        src    = st_q.hv ? picked : '0;
        if (accept) begin
            st_d.hold = smp_data;
            st_d.hv   = 1'b1;
            st_d.run  = 1'b1;
        end
        if (launch) begin
            st_d.ws = ws_now;
            if (word_start) begin
                // the holding register is emptied, or an empty one is recorded
                if (st_q.hv) st_d.hv  = 1'b0;
                else         st_d.udf = 1'b1;
                st_d.sd = MUTE ? 1'b0 : src[DATA_W-1];
                st_d.sh = src << 1;
            end else if (in_data) begin
                st_d.sd = MUTE ? 1'b0 : st_q.sh[DATA_W-1];
                st_d.sh = st_q.sh << 1;
            end else begin
                st_d.sd = PAD_HIGH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk      = sck_raw ^ SCK_INV;
    assign wsel      = st_q.ws ^ WS_INV;
    assign sdata     = st_q.sd;
    assign underflow = st_q.udf;
    assign cfg_err   = CFG_BAD;

endmodule

// File: rtl/mctx_checker.sv
module mctx_checker #(
    parameter bit SCK_INV = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic smp_valid,
    input logic smp_ready,
    input logic bclk,
    input logic wsel,
    input logic sdata,
    input logic underflow,
    input logic cfg_err
);
    // R3: word select moves only together with the falling raw bit clock
    a_r3_ws_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wsel) |-> (bclk == SCK_INV));

    // R3: data moves only together with the falling raw bit clock
    a_r3_sd_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> (bclk == SCK_INV));

    // R9: an accepted sample fills the holding register
    a_r9_full_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready);

    // R10: the underflow flag never clears
    a_r10_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R11: a refused configuration keeps the bus quiet
    a_r11_bad_cfg_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!smp_ready && !sdata && (bclk == SCK_INV)));

endmodule

bind mc_audio_tx mctx_checker #(.SCK_INV(SCK_INV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .bclk      (bclk),
    .wsel      (wsel),
    .sdata     (sdata),
    .underflow (underflow),
    .cfg_err   (cfg_err)
);

// File: tb/mctx_probe.sv
module mctx_probe #(
    parameter int         DATA_W    = 16,
    parameter int         SYS_W     = 32,
    parameter logic [1:0] CHAN_SEL  = 2'b01,
    parameter bit         PAD_FIRST = 1'b0,
    parameter bit         PAD_HIGH  = 1'b0,
    parameter bit         ALIGN_LSB = 1'b0,
    parameter bit         MUTE      = 1'b0,
    parameter bit         SCK_INV   = 1'b0,
    parameter bit         WS_INV    = 1'b0,
    parameter bit         NO_DELAY  = 1'b0,
    parameter int         HALF      = 4,
    parameter int         SEED      = 1,
    parameter int         FEED_FR   = 4,
    parameter int         TOTAL_FR  = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] smp_data,
    output logic        smp_valid,
    input  logic        smp_ready,
    input  logic        bclk,
    input  logic        wsel,
    input  logic        sdata,
    input  logic        underflow,
    output logic        done,
    output int          n_chk,
    output int          n_fail
);
    localparam int NW    = int'(CHAN_SEL) + 1;
    localparam int FRAME = 2 * SYS_W;
    localparam int PADW  = SYS_W - NW * DATA_W;

    logic [31:0] sent[$];
    int   k;
    logic feeding;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s in %m: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_ws(input int bitn);
        return ((bitn % FRAME) >= SYS_W) ^ WS_INV;
    endfunction

    // expected data line for bit number bitn, with the requirement it belongs to
    function automatic logic exp_sd(input int bitn, output string tag);
        int dpos, sw, db, e, n, j;
        logic [31:0] w;
        if (!NO_DELAY && bitn == 0) begin
            tag = "R8";
            return PAD_HIGH;
        end
        dpos = NO_DELAY ? bitn : bitn - 1;
        sw   = dpos / SYS_W;
        db   = dpos % SYS_W;
        tag  = "R4 R5";
        if (PAD_FIRST) begin
            if (db < PADW) return PAD_HIGH;
            e = db - PADW;
        end else begin
            if (db >= NW * DATA_W) return PAD_HIGH;
            e = db;
        end
        n = sw * NW + e / DATA_W;
        j = e % DATA_W;
        if (n >= sent.size()) begin
            tag = "R10";
            return 1'b0;
        end
        if (MUTE) begin
            tag = "R7";
            return 1'b0;
        end
        tag = "R1 R6 R9";
        w = ALIGN_LSB ? sent[n] : (sent[n] >> (32 - DATA_W));
        return w[DATA_W - 1 - j];
    endfunction

    initial begin
        n_chk = 0; n_fail = 0; done = 1'b0; k = 0;
        feeding = 1'b0; smp_valid = 1'b0;
        void'($urandom(SEED));
        smp_data = $urandom;
        @(posedge rst_n);
        @(negedge clk);
        chk("R12", "ready after reset", 32'(smp_ready), 32'd1);
        chk("R12", "underflow after reset", 32'(underflow), 32'd0);
        chk("R12", "bclk idle", 32'(bclk), 32'(SCK_INV));
        chk("R12", "wsel idle", 32'(wsel), 32'(WS_INV));
        chk("R12", "sdata idle", 32'(sdata), 32'd0);
        repeat (8) @(negedge clk);
        chk("R12", "bclk idle without samples", 32'(bclk), 32'(SCK_INV));
        feeding = 1'b1;
        wait (k >= FEED_FR * FRAME);
        feeding = 1'b0;
        wait (k >= TOTAL_FR * FRAME);
        chk("R10", "underflow after starving", 32'(underflow), 32'd1);
        repeat (6 * HALF) @(negedge clk);
        chk("R10", "underflow stays set", 32'(underflow), 32'd1);
        done = 1'b1;
    end

    initial begin
        logic pend, prev, raw, rise, e;
        int   cyc, last;
        string tag;
        pend = 1'b0; prev = 1'b0; cyc = 0; last = -1;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            cyc++;
            if (pend) begin
                sent.push_back(smp_data);
                smp_data = $urandom;
            end
            smp_valid = feeding;
            pend = smp_valid && smp_ready;
            raw  = bclk ^ SCK_INV;
            rise = raw && !prev;
            prev = raw;
            if (rise && !done) begin
                if (last >= 0) chk("R3", "bit clock period", 32'(cyc - last), 32'(2 * HALF));
                last = cyc;
                chk("R2", "word select", 32'(wsel), 32'(exp_ws(k)));
                e = exp_sd(k, tag);
                chk(tag, "data bit", 32'(sdata), 32'(e));
                if (feeding) chk("R10", "no underflow while fed", 32'(underflow), 32'd0);
                k++;
            end
        end
    end

endmodule

// File: tb/sim_mc_audio_tx.sv
`timescale 1ns/1ps
module sim_mc_audio_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int t_chk = 0;
    int t_fail = 0;

    // instance A: four 6-bit words in 32, padding first and high, delayed
    logic [31:0] a_data; logic a_valid, a_ready, a_bclk, a_wsel, a_sd, a_udf, a_err, a_done;
    int a_chk, a_fail;
    mc_audio_tx #(.DATA_W(6), .SYS_W(32), .CHAN_SEL(2'b11), .PAD_FIRST(1'b1), .PAD_HIGH(1'b1),
                  .ALIGN_LSB(1'b0), .MUTE(1'b0), .SCK_INV(1'b0), .WS_INV(1'b0),
                  .NO_DELAY(1'b0), .HALF(2)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_data(a_data), .smp_valid(a_valid), .smp_ready(a_ready),
        .bclk(a_bclk), .wsel(a_wsel), .sdata(a_sd), .underflow(a_udf), .cfg_err(a_err));
    mctx_probe #(.DATA_W(6), .SYS_W(32), .CHAN_SEL(2'b11), .PAD_FIRST(1'b1), .PAD_HIGH(1'b1),
                 .ALIGN_LSB(1'b0), .MUTE(1'b0), .SCK_INV(1'b0), .WS_INV(1'b0),
                 .NO_DELAY(1'b0), .HALF(2), .SEED(11)) p0 (
        .clk(clk), .rst_n(rst_n), .smp_data(a_data), .smp_valid(a_valid), .smp_ready(a_ready),
        .bclk(a_bclk), .wsel(a_wsel), .sdata(a_sd), .underflow(a_udf), .done(a_done),
        .n_chk(a_chk), .n_fail(a_fail));

    // instance B: two 10-bit words in 24, padding last and low, LSB aligned, no delay, inverted
    logic [31:0] b_data; logic b_valid, b_ready, b_bclk, b_wsel, b_sd, b_udf, b_err, b_done;
    int b_chk, b_fail;
    mc_audio_tx #(.DATA_W(10), .SYS_W(24), .CHAN_SEL(2'b01), .PAD_FIRST(1'b0), .PAD_HIGH(1'b0),
                  .ALIGN_LSB(1'b1), .MUTE(1'b0), .SCK_INV(1'b1), .WS_INV(1'b1),
                  .NO_DELAY(1'b1), .HALF(3)) u1 (
        .clk(clk), .rst_n(rst_n), .smp_data(b_data), .smp_valid(b_valid), .smp_ready(b_ready),
        .bclk(b_bclk), .wsel(b_wsel), .sdata(b_sd), .underflow(b_udf), .cfg_err(b_err));
    mctx_probe #(.DATA_W(10), .SYS_W(24), .CHAN_SEL(2'b01), .PAD_FIRST(1'b0), .PAD_HIGH(1'b0),
                 .ALIGN_LSB(1'b1), .MUTE(1'b0), .SCK_INV(1'b1), .WS_INV(1'b1),
                 .NO_DELAY(1'b1), .HALF(3), .SEED(23)) p1 (
        .clk(clk), .rst_n(rst_n), .smp_data(b_data), .smp_valid(b_valid), .smp_ready(b_ready),
        .bclk(b_bclk), .wsel(b_wsel), .sdata(b_sd), .underflow(b_udf), .done(b_done),
        .n_chk(b_chk), .n_fail(b_fail));

    // instance C: three 4-bit words in 16, muted, padding high
    logic [31:0] c_data; logic c_valid, c_ready, c_bclk, c_wsel, c_sd, c_udf, c_err, c_done;
    int c_chk, c_fail;
    mc_audio_tx #(.DATA_W(4), .SYS_W(16), .CHAN_SEL(2'b10), .PAD_FIRST(1'b0), .PAD_HIGH(1'b1),
                  .ALIGN_LSB(1'b0), .MUTE(1'b1), .SCK_INV(1'b0), .WS_INV(1'b0),
                  .NO_DELAY(1'b0), .HALF(1)) u3 (
        .clk(clk), .rst_n(rst_n), .smp_data(c_data), .smp_valid(c_valid), .smp_ready(c_ready),
        .bclk(c_bclk), .wsel(c_wsel), .sdata(c_sd), .underflow(c_udf), .cfg_err(c_err));
    mctx_probe #(.DATA_W(4), .SYS_W(16), .CHAN_SEL(2'b10), .PAD_FIRST(1'b0), .PAD_HIGH(1'b1),
                 .ALIGN_LSB(1'b0), .MUTE(1'b1), .SCK_INV(1'b0), .WS_INV(1'b0),
                 .NO_DELAY(1'b0), .HALF(1), .SEED(37)) p3 (
        .clk(clk), .rst_n(rst_n), .smp_data(c_data), .smp_valid(c_valid), .smp_ready(c_ready),
        .bclk(c_bclk), .wsel(c_wsel), .sdata(c_sd), .underflow(c_udf), .done(c_done),
        .n_chk(c_chk), .n_fail(c_fail));

    // instance D: three 12-bit words cannot fit in 32
    logic [31:0] d_data; logic d_valid, d_ready, d_bclk, d_wsel, d_sd, d_udf, d_err;
    mc_audio_tx #(.DATA_W(12), .SYS_W(32), .CHAN_SEL(2'b10), .HALF(2)) u2 (
        .clk(clk), .rst_n(rst_n), .smp_data(d_data), .smp_valid(d_valid), .smp_ready(d_ready),
        .bclk(d_bclk), .wsel(d_wsel), .sdata(d_sd), .underflow(d_udf), .cfg_err(d_err));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        t_chk++;
        if (act !== exp) begin
            t_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        int cycles;
        d_data  = 32'hA5A5_5A5A;
        d_valid = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "fitting set has no error", 32'(a_err), 32'd0);
        chk("R11", "fitting set B has no error", 32'(b_err), 32'd0);
        chk("R11", "refused set flags error", 32'(d_err), 32'd1);
        repeat (40) @(negedge clk);
        chk("R11", "refused set never ready", 32'(d_ready), 32'd0);
        chk("R11", "refused set bclk idle", 32'(d_bclk), 32'd0);
        chk("R11", "refused set wsel idle", 32'(d_wsel), 32'd0);
        chk("R11", "refused set data idle", 32'(d_sd), 32'd0);
        chk("R11", "refused set no underflow", 32'(d_udf), 32'd0);
        cycles = 0;
        while (!(a_done && b_done && c_done) && cycles < 100000) begin
            @(negedge clk);
            cycles++;
        end
        if (!(a_done && b_done && c_done)) begin
            t_chk++;
            t_fail++;
            $display("FAIL watchdog: actual %0d expected done", cycles);
        end
        $display("  [TB] %0d tests run, %0d failed",
                 t_chk + a_chk + b_chk + c_chk, t_fail + a_fail + b_fail + c_fail);
        $finish;
    end

endmodule